// File: doc/BRIEF.md
# Change-of-State Digital Input Controller

This block samples 48 digital input lines arranged as six groups of eight and presents them to a host through an eight-byte register window on a simple synchronous bus. Each group appears as a read-only data byte. The window skips one offset, so the groups sit at offsets 0, 1, 2, 4, 5 and 6 in group order. All 48 lines are inputs only. The block has no direction register and no output register.

Every line passes through a two-flop synchroniser. The block then compares the synchronised value with the value it sampled on the previous cycle. Change-of-state detection is switched on per group, not per pin. When detection is on for a group, a transition in either direction on any of its eight lines latches a flag for that group. The interrupt request output stays high while a flag is latched in any enabled group.

Offset 7 serves two purposes. A write to it loads the group enable mask. A read from it returns the latched group flags together with an active-low pending bit, and the same read clears the flags.

Top module: `cos_input_ctrl`

## Requirements
- R1: After synchronous reset, all group enables and all group flags are zero and `irq` is low. A read of offset 7 then returns 0x40.
- R2: A read of offset 0, 1, 2, 4, 5 or 6 returns the synchronised byte of group 0, 1, 2, 3, 4 or 5 respectively. Group g holds input lines 8g to 8g+7, with line 8g in bit 0.
- R3: A read of offset 3 returns 0x00.
- R4: A write to offset 7 loads bits 5:0 of the write data as the group enable mask, where bit n enables group n. Writes to any other offset change nothing.
- R5: In an enabled group, a rising transition on any one of its lines latches that group's flag. A falling transition does the same.
- R6: A group whose enable bit is 0 never latches a flag, and `irq` stays low because of it.
- R7: A read of offset 7 returns the flags of groups 0 to 5 in bits 5:0. Bit 6 is 0 while an interrupt is pending and 1 otherwise. Bit 7 is always 0.
- R8: A read of offset 7 clears every latched flag. A transition that is detected in the same cycle as that read stays latched.
- R9: `irq` rises on the third rising clock edge after an input line changes, counting two synchroniser edges and one flag edge. It then stays high until it is cleared.
- R10: When a group is disabled by a write to offset 7, its flag is dropped. `irq` no longer counts that group from the cycle after the write.
- R11: Read data is registered. `bus_rdata` shows the result one rising edge after the cycle in which `bus_rd` is sampled high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 48 | Asynchronous digital input lines |
| bus_addr | input | 3 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
A change on an input line takes two edges to reach the data bytes and three edges to set a flag and `irq`. A read result appears on the edge that samples the strobe. The bench therefore drives every stimulus on a falling edge and counts the exact number of rising edges before it samples on a falling edge. It also samples one edge early to confirm that `irq` is not yet high. The same-cycle case is set up by placing the status read strobe on the third edge after a change. That read must report the old, cleared status, and the new flag must survive the read.

// File: rtl/cosin_pkg.sv
package cosin_pkg;

    localparam int NUM_GROUPS = 6;
    localparam int GROUP_BITS = 8;
    localparam int ADDR_W     = 3;
    localparam int BYTE_W     = 8;
    localparam logic [ADDR_W-1:0] CTRL_OFFSET = 3'd7;
    localparam logic [ADDR_W-1:0] HOLE_OFFSET = 3'd3;
    localparam int PEND_BIT   = 6;

    typedef enum logic [1:0] {
        ACC_GROUP = 2'd0,
        ACC_CTRL  = 2'd1,
        ACC_EMPTY = 2'd2
    } access_e;

    typedef struct packed {
        access_e             kind;
        logic [ADDR_W-1:0]   group;
    } decode_t;

    // Offsets below the hole map straight to groups; offsets above it shift down by one.
    function automatic decode_t decode_offset(input logic [ADDR_W-1:0] off);
        decode_t d;
        d.group = '0;
        if (off == CTRL_OFFSET) begin
            d.kind = ACC_CTRL;
        end else if (off < HOLE_OFFSET) begin
            d.kind  = ACC_GROUP;
            d.group = off;
        end else if (off > HOLE_OFFSET) begin
            d.kind  = ACC_GROUP;
            d.group = off - 3'd1;
        end else begin
            d.kind = ACC_EMPTY;
        end
        return d;
    endfunction

endpackage

// File: rtl/cosin_sync.sv
module cosin_sync #(
    parameter int WIDTH  = 48,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cosin_detect.sv
module cosin_detect #(
    parameter int GROUPS = 6,
    parameter int GBITS  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [GROUPS*GBITS-1:0] smp,
    input  logic [GROUPS-1:0]       enable,
    input  logic                    clear,
    output logic [GROUPS-1:0]       flags,
    output logic [GROUPS-1:0]       hit
);
    localparam int LINES = GROUPS * GBITS;

    logic [LINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= smp;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [GBITS-1:0] diff;
        logic             flag_q;
        logic             kept;

        assign diff   = smp[g*GBITS +: GBITS] ^ prev_q[g*GBITS +: GBITS];
        assign hit[g] = enable[g] & (|diff);
        assign kept   = flag_q & ~clear;

        always_ff @(posedge clk) begin
            if (rst) flag_q <= 1'b0;
            else     flag_q <= (kept | hit[g]) & enable[g];
        end

        assign flags[g] = flag_q;
    end
endmodule

// File: rtl/cosin_regs.sv
module cosin_regs
    import cosin_pkg::*;
#(
    parameter int GROUPS = 6,
    parameter int GBITS  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr,
    input  logic                    rd,
    input  logic [BYTE_W-1:0]       wdata,
    input  logic [GROUPS*GBITS-1:0] smp,
    input  logic [GROUPS-1:0]       flags,
    input  logic                    pending,
    output logic [GROUPS-1:0]       enable,
    output logic                    clear,
    output logic [BYTE_W-1:0]       rdata
);
    decode_t          dec;
    logic [BYTE_W-1:0] rd_next;
    logic [BYTE_W-1:0] status;
    logic [GROUPS-1:0] en_q;

    assign dec = decode_offset(addr);

    always_comb begin
        status           = '0;
        status[GROUPS-1:0] = flags;
        status[PEND_BIT] = ~pending;
    end

    always_comb begin
        unique case (dec.kind)
            ACC_GROUP: rd_next = BYTE_W'(smp[32'(dec.group)*GBITS +: GBITS]);
            ACC_CTRL:  rd_next = status;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            rdata <= '0;
        end else begin
            if (wr && dec.kind == ACC_CTRL) en_q <= wdata[GROUPS-1:0];
            if (rd) rdata <= rd_next;
        end
    end

    assign enable = en_q;
    assign clear  = rd && dec.kind == ACC_CTRL;
endmodule

// File: rtl/cos_input_ctrl.sv
module cos_input_ctrl
    import cosin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_GROUPS*GROUP_BITS-1:0]  pin_in,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    input  logic [BYTE_W-1:0]                 bus_wdata,
    output logic [BYTE_W-1:0]                 bus_rdata,
    output logic                              irq
);
    localparam int LINES = NUM_GROUPS * GROUP_BITS;

    logic [LINES-1:0]      pin_s;
    logic [NUM_GROUPS-1:0] en_q;
    logic [NUM_GROUPS-1:0] grp_flag;
    logic [NUM_GROUPS-1:0] grp_hit;
    logic                  clr_rd;

    cosin_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_s)
    );

    cosin_detect #(.GROUPS(NUM_GROUPS), .GBITS(GROUP_BITS)) u_detect (
        .clk    (clk),
        .rst    (rst),
        .smp    (pin_s),
        .enable (en_q),
        .clear  (clr_rd),
        .flags  (grp_flag),
        .hit    (grp_hit)
    );

    cosin_regs #(.GROUPS(NUM_GROUPS), .GBITS(GROUP_BITS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .smp     (pin_s),
        .flags   (grp_flag),
        .pending (irq),
        .enable  (en_q),
        .clear   (clr_rd),
        .rdata   (bus_rdata)
    );

    assign irq = |(grp_flag & en_q);
endmodule

// File: rtl/cosin_checker.sv
module cosin_checker
    import cosin_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [BYTE_W-1:0]     bus_wdata,
    input logic [BYTE_W-1:0]     bus_rdata,
    input logic                  irq,
    input logic [NUM_GROUPS-1:0] en,
    input logic [NUM_GROUPS-1:0] hit
);
    p_hole_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == HOLE_OFFSET) |=> (bus_rdata == 8'h00));

    p_pending_low_active_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == CTRL_OFFSET) |=> (bus_rdata[PEND_BIT] == !$past(irq) && !bus_rdata[7]));

    p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en != '0));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == CTRL_OFFSET && hit == '0) |=> !irq);

    p_irq_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !(bus_addr == CTRL_OFFSET && (bus_rd || bus_wr))) |=> irq);

    p_disable_all_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == CTRL_OFFSET && bus_wdata[NUM_GROUPS-1:0] == '0) |=> !irq);

    p_rdata_stable_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind cos_input_ctrl cosin_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .en        (en_q),
    .hit       (grp_hit)
);

// File: tb/cos_input_ctrl_test.sv
module cos_input_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] pin_in = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cos_input_ctrl uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        ticks(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        ticks(1);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [2:0] grp_off(input int g);
        return (g < 3) ? 3'(g) : 3'(g + 1);
    endfunction

    initial begin
        logic [7:0] v;
        @(negedge clk);
        ticks(2);
        rst = 1'b0;
        // R1 reset state
        check({7'b0, irq}, 8'h00, "R1 irq after reset");
        rd(3'd7, v);
        check(v, 8'h40, "R1 status after reset");

        // R2 data map, several patterns
        for (int p = 0; p < 4; p++) begin
            for (int g = 0; g < 6; g++)
                pin_in[g*8 +: 8] = 8'(p * 37 + g * 19 + 5) ^ (p[0] ? 8'hA5 : 8'h00);
            ticks(3);
            for (int g = 0; g < 6; g++) begin
                rd(grp_off(g), v);
                check(v, pin_in[g*8 +: 8], "R2 group data byte");
            end
            rd(3'd3, v);
            check(v, 8'h00, "R3 offset 3 reads zero");
            check({7'b0, irq}, 8'h00, "R6 no irq while all disabled");
        end

        // R4 writes elsewhere ignored
        wr(3'd3, 8'h3F); wr(3'd0, 8'h3F); wr(3'd6, 8'h3F);
        pin_in = ~pin_in;
        ticks(5);
        check({7'b0, irq}, 8'h00, "R4 write to non-control offset ignored");
        rd(3'd7, v);
        check(v, 8'h40, "R4 status unchanged after ignored writes");

        // R5/R7/R9 sweep over every line, both edges
        for (int g = 0; g < 6; g++) begin
            wr(3'd7, 8'(1 << g));
            rd(3'd7, v);
            for (int b = 0; b < 8; b++) begin
                for (int e = 0; e < 2; e++) begin
                    pin_in[g*8+b] = ~pin_in[g*8+b];
                    ticks(2);
                    check({7'b0, irq}, 8'h00, "R9 irq not before third edge");
                    ticks(1);
                    check({7'b0, irq}, 8'h01, "R5 R9 irq on third edge");
                    rd(3'd7, v);
                    check(v, 8'(1 << g), "R7 status flags with pending low");
                    check({7'b0, irq}, 8'h00, "R8 irq cleared by status read");
                end
            end
        end

        // R6 disabled group never latches
        wr(3'd7, 8'h01);
        pin_in[30] = ~pin_in[30];
        ticks(5);
        check({7'b0, irq}, 8'h00, "R6 disabled group ignored");
        rd(3'd7, v);
        check(v, 8'h40, "R6 status without flag");

        // R8 edge in the same cycle as status read survives
        wr(3'd7, 8'h3F);
        pin_in[9] = ~pin_in[9];
        ticks(2);
        rd(3'd7, v);
        check(v, 8'h40, "R8 read before flag returns old status");
        check({7'b0, irq}, 8'h01, "R8 same-cycle edge stays latched");
        rd(3'd7, v);
        check(v, 8'h02, "R8 latched flag reported");

        // Multiple groups at once
        pin_in[0] = ~pin_in[0]; pin_in[47] = ~pin_in[47];
        ticks(3);
        rd(3'd7, v);
        check(v, 8'h21, "R7 two group flags");

        // R10 disabling drops flag
        pin_in[20] = ~pin_in[20];
        ticks(3);
        check({7'b0, irq}, 8'h01, "R10 flag set before disable");
        wr(3'd7, 8'h00);
        check({7'b0, irq}, 8'h00, "R10 irq dropped after disable");
        wr(3'd7, 8'h04);
        check({7'b0, irq}, 8'h00, "R10 flag gone after re-enable");
        rd(3'd7, v);
        check(v, 8'h40, "R10 status after re-enable");

        // R11 read data holds between reads
        rd(3'd1, v);
        pin_in[15:8] = ~pin_in[15:8];
        ticks(4);
        check(bus_rdata, v, "R11 read data held without strobe");

        done = 1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule